// File: doc/BRIEF.md
# Card Slot Status and Interrupt Register

This block holds the read-side status bytes for three card slots of a multi-slot smart card interface. Each slot has one status byte. The byte mixes two kinds of bit. Some are live copies of the slot's current state: card active, clock running from the internal oscillator, and the presence pin. The others are sticky event flags set by single-cycle pulses from that slot's controller: early answer, no answer (mute), protection fault and supervisor fault. A host reads a byte by pulsing a read strobe with an address. That read returns the byte and clears the sticky flags of the addressed slot only. An active-low interrupt line stays low while any sticky flag is set in any slot.

Each slot has a small acknowledge state machine with two states. After reset every slot starts in SLOT_POR_HOLD, where the supervisor flag reads as set. The first read of that slot takes the transition "acknowledge" to SLOT_ARMED. SLOT_ARMED has no exit other than reset. In it, the supervisor flag reads set only after a supervisor fault pulse and until the next read. Because of this, the interrupt is asserted from power-on until software has read every slot once.

Top module: `card_slot_status`

## Requirements
- R1: Each status byte has this layout: bit 7 card active, bit 6 early answer, bit 5 mute, bit 4 protection fault, bit 3 supervisor fault, bit 2 clock-on-internal-oscillator, bit 1 reserved, bit 0 presence pin.
- R2: Addresses 03h, 04h and 05h select slots 0, 1 and 2 respectively.
- R3: A one-cycle pulse on the early, mute or protection event input of a slot sets the matching bit. The bit stays set until that slot's byte is read, and it reads 0 after that read.
- R4: The supervisor bit of a slot reads 1 from reset until the first read of that slot. After that, it is set by a supervisor event pulse and cleared by a read.
- R5: irq_n is low in the cycle after any sticky bit (including the reset-held supervisor bit) becomes set in any slot. It returns high in the cycle after the read that clears the last such bit.
- R6: The active, clock and presence bits return the values of slot_active, slot_clk_int and slot_pres in the cycle the read strobe is sampled.
- R7: Bit 1 always reads 0.
- R8: If an event pulse arrives in the same cycle as a read of its slot, that read returns the bit's previous value and the bit is set afterwards.
- R9: A read clears only the sticky bits of the addressed slot.
- R10: A read of any other address returns 00h and changes no flag.
- R11: rd_data is registered. It carries the result one cycle after rd_en is sampled high and holds that value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |
| slot_active | input | 3 | Live card-active state per slot |
| slot_clk_int | input | 3 | Live clock-on-internal-oscillator state per slot |
| slot_pres | input | 3 | Live presence pin per slot |
| evt_early | input | 3 | Early-answer event pulse per slot |
| evt_mute | input | 3 | No-answer event pulse per slot |
| evt_prot | input | 3 | Overload or overheat event pulse per slot |
| evt_supl | input | 3 | Supervisor fault event pulse per slot |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check the following on every cycle:
- bit 1 is always zero;
- unmapped reads return zero;
- rd_data holds between reads;
- any event pulse pulls irq_n low on the next cycle, including a pulse that collides with a read;
- a read of slot 0 returns that cycle's active input.

Other behaviour depends on history, and only the bench's scenarios can show it:
- clearing on read, with the old value returned;
- the supervisor bit held from reset until each slot's first read;
- a read leaving the other slots untouched;
- irq_n releasing only after the last flag is gone.

// File: rtl/card_stat_pkg.sv
package card_stat_pkg;

    typedef enum logic {
        SLOT_POR_HOLD = 1'b0,
        SLOT_ARMED    = 1'b1
    } slot_st_e;

    typedef struct packed {
        logic early;
        logic mute;
        logic prot;
        logic supl;
    } evt_flags_t;

    localparam int BYTE_W    = 8;
    localparam int POS_ACT   = 7;
    localparam int POS_EARLY = 6;
    localparam int POS_MUTE  = 5;
    localparam int POS_PROT  = 4;
    localparam int POS_SUPL  = 3;
    localparam int POS_CLK   = 2;
    localparam int POS_RSVD  = 1;
    localparam int POS_PRES  = 0;

endpackage

// File: rtl/cs_slot_flags.sv
module cs_slot_flags
    import card_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_hit,
    input  evt_flags_t evt,
    output evt_flags_t flags,
    output logic       irq_req
);

    slot_st_e   st_q;
    slot_st_e   st_d;
    evt_flags_t sticky_q;
    evt_flags_t sticky_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= SLOT_POR_HOLD;
            sticky_q <= '0;
        end else begin
            st_q     <= st_d;
            sticky_q <= sticky_d;
        end
    end

    // Next state: a read acknowledges the power-on hold
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_POR_HOLD: if (rd_hit) st_d = SLOT_ARMED;
            SLOT_ARMED:    st_d = SLOT_ARMED;
            default:       st_d = SLOT_POR_HOLD;
        endcase
    end

    // Sticky update: an event in the read cycle survives the clear
    always_comb begin
        sticky_d = rd_hit ? evt_flags_t'('0) : sticky_q;
        sticky_d = sticky_d | evt;
    end

    // Outputs
    always_comb begin
        flags = sticky_q;
        unique case (st_q)
            SLOT_POR_HOLD: flags.supl = 1'b1;
            SLOT_ARMED:    flags.supl = sticky_q.supl;
            default:       flags.supl = 1'b1;
        endcase
        irq_req = |flags;
    end

endmodule

// File: rtl/cs_addr_dec.sv
module cs_addr_dec #(
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 3,
    parameter int N_SLOTS   = 3
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [N_SLOTS-1:0] sel,
    output logic              hit
);

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_sel
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE_ADDR + g);
        assign sel[g] = rd_en && (rd_addr == SLOT_ADDR);
    end

    assign hit = |sel;

endmodule

// File: rtl/cs_rd_port.sv
module cs_rd_port #(
    parameter int N_SLOTS = 3,
    parameter int BYTE_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic [N_SLOTS-1:0]             sel,
    input  logic [N_SLOTS-1:0][BYTE_W-1:0] bytes,
    output logic [BYTE_W-1:0]              rd_data
);

    logic [BYTE_W-1:0] mux;

    always_comb begin
        mux = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            mux = mux | (bytes[i] & {BYTE_W{sel[i]}});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mux;
        end
    end

endmodule

// File: rtl/card_slot_status.sv
module card_slot_status
    import card_stat_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 3,
    parameter int N_SLOTS   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [7:0]         rd_data,
    input  logic [N_SLOTS-1:0] slot_active,
    input  logic [N_SLOTS-1:0] slot_clk_int,
    input  logic [N_SLOTS-1:0] slot_pres,
    input  logic [N_SLOTS-1:0] evt_early,
    input  logic [N_SLOTS-1:0] evt_mute,
    input  logic [N_SLOTS-1:0] evt_prot,
    input  logic [N_SLOTS-1:0] evt_supl,
    output logic               irq_n
);

    logic [N_SLOTS-1:0]             sel;
    logic                           hit;
    logic [N_SLOTS-1:0]             irq_req;
    logic [N_SLOTS-1:0][BYTE_W-1:0] bytes;

    cs_addr_dec #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR),
        .N_SLOTS  (N_SLOTS)
    ) u_dec (
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .sel    (sel),
        .hit    (hit)
    );

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        evt_flags_t evt;
        evt_flags_t flags;

        assign evt = '{early: evt_early[g], mute: evt_mute[g],
                       prot: evt_prot[g], supl: evt_supl[g]};

        cs_slot_flags u_flags (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_hit (sel[g]),
            .evt    (evt),
            .flags  (flags),
            .irq_req(irq_req[g])
        );

        always_comb begin
            bytes[g]            = '0;
            bytes[g][POS_ACT]   = slot_active[g];
            bytes[g][POS_EARLY] = flags.early;
            bytes[g][POS_MUTE]  = flags.mute;
            bytes[g][POS_PROT]  = flags.prot;
            bytes[g][POS_SUPL]  = flags.supl;
            bytes[g][POS_CLK]   = slot_clk_int[g];
            bytes[g][POS_RSVD]  = 1'b0;
            bytes[g][POS_PRES]  = slot_pres[g];
        end
    end

    cs_rd_port #(
        .N_SLOTS(N_SLOTS),
        .BYTE_W (BYTE_W)
    ) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .sel    (sel),
        .bytes  (bytes),
        .rd_data(rd_data)
    );

    assign irq_n = ~|irq_req;

endmodule

// File: rtl/card_slot_status_chk.sv
module card_slot_status_chk #(
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 3,
    parameter int N_SLOTS   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [7:0]         rd_data,
    input logic [N_SLOTS-1:0] slot_active,
    input logic [N_SLOTS-1:0] evt_early,
    input logic [N_SLOTS-1:0] evt_mute,
    input logic [N_SLOTS-1:0] evt_prot,
    input logic [N_SLOTS-1:0] evt_supl,
    input logic               irq_n
);

    localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(BASE_ADDR + N_SLOTS - 1);

    logic mapped;
    assign mapped = (rd_addr >= FIRST) && (rd_addr <= LAST);

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[1] == 1'b0);

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> (rd_data == 8'h00));

    // R5
    event_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|{evt_early, evt_mute, evt_prot, evt_supl}) |=> !irq_n);

    // R8
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == FIRST && evt_prot[0]) |=> !irq_n);

    // R6
    live_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == FIRST) |=> (rd_data[7] == $past(slot_active[0])));

    // R11
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind card_slot_status card_slot_status_chk #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .N_SLOTS  (N_SLOTS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .slot_active(slot_active),
    .evt_early  (evt_early),
    .evt_mute   (evt_mute),
    .evt_prot   (evt_prot),
    .evt_supl   (evt_supl),
    .irq_n      (irq_n)
);

// File: tb/card_slot_status_tb.sv
`timescale 1ns/1ps
module card_slot_status_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [2:0] slot_active = '0, slot_clk_int = '0, slot_pres = '0;
    logic [2:0] evt_early = '0, evt_mute = '0, evt_prot = '0, evt_supl = '0;
    logic       irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model: [slot][kind] kind 0 early,1 mute,2 prot,3 supl
    bit m_flag [3][4];
    bit m_por  [3];

    always #2.5 clk = ~clk;

    card_slot_status u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .slot_active(slot_active),
        .slot_clk_int(slot_clk_int), .slot_pres(slot_pres),
        .evt_early(evt_early), .evt_mute(evt_mute), .evt_prot(evt_prot),
        .evt_supl(evt_supl), .irq_n(irq_n)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(int s);
        return {slot_active[s], m_flag[s][0], m_flag[s][1], m_flag[s][2],
                m_flag[s][3] | m_por[s], slot_clk_int[s], 1'b0, slot_pres[s]};
    endfunction

    function automatic logic exp_irq();
        logic any = 1'b0;
        for (int s = 0; s < 3; s++) begin
            any |= m_por[s];
            for (int k = 0; k < 4; k++) any |= m_flag[s][k];
        end
        return ~any;
    endfunction

    task automatic set_evt(int s, int k, logic v);
        case (k)
            0: evt_early[s] = v;
            1: evt_mute[s]  = v;
            2: evt_prot[s]  = v;
            default: evt_supl[s] = v;
        endcase
    endtask

    task automatic pulse(int s, int k);
        @(negedge clk);
        set_evt(s, k, 1'b1);
        @(negedge clk);
        set_evt(s, k, 1'b0);
        m_flag[s][k] = 1'b1;
    endtask

    // Read with optional same-cycle event (ev_s < 0 means none)
    task automatic do_read(int addr, string req, int ev_s, int ev_k);
        logic [7:0] exp;
        int s;
        @(negedge clk);
        s = addr - 3;
        exp = (s >= 0 && s < 3) ? exp_byte(s) : 8'h00;
        rd_en = 1'b1;
        rd_addr = 8'(addr);
        if (ev_s >= 0) set_evt(ev_s, ev_k, 1'b1);
        @(negedge clk);
        rd_en = 1'b0;
        if (ev_s >= 0) set_evt(ev_s, ev_k, 1'b0);
        check(req, rd_data, exp);
        if (s >= 0 && s < 3) begin
            for (int k = 0; k < 4; k++) m_flag[s][k] = 1'b0;
            m_por[s] = 1'b0;
        end
        if (ev_s >= 0) m_flag[ev_s][ev_k] = 1'b1;
    endtask

    task automatic check_irq(string req);
        check(req, {7'd0, irq_n}, {7'd0, exp_irq()});
    endtask

    initial begin
        for (int s = 0; s < 3; s++) begin
            m_por[s] = 1'b1;
            for (int k = 0; k < 4; k++) m_flag[s][k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset data", rd_data, 8'h00);
        check_irq("R4 R5 irq at power-on");

        // R2 R4 R6: first reads show the held supervisor bit
        slot_active = 3'b101; slot_clk_int = 3'b011; slot_pres = 3'b110;
        for (int a = 3; a <= 5; a++) begin
            check_irq("R5 irq before ack");
            do_read(a, "R2 R4 R6 first read", -1, 0);
        end
        check_irq("R5 irq released after acks");
        do_read(4, "R4 supervisor cleared after ack", -1, 0);

        // R1 R3 R4 R5 R6 R7 sweep over slot, event kind and live pattern
        for (int s = 0; s < 3; s++) begin
            for (int k = 0; k < 4; k++) begin
                for (int p = 0; p < 8; p++) begin
                    slot_active[s] = p[0]; slot_clk_int[s] = p[1]; slot_pres[s] = p[2];
                    pulse(s, k);
                    check_irq("R5 irq after event");
                    do_read(3 + s, "R1 R3 R4 R6 R7 flagged byte", -1, 0);
                    check_irq("R5 irq after clear");
                    do_read(3 + s, "R3 R4 cleared byte", -1, 0);
                end
            end
        end

        // R8: event collides with a read of its slot
        do_read(3, "R8 read returns old value", 0, 2);
        check_irq("R8 irq stays low");
        do_read(3, "R8 flag kept after collision", -1, 0);
        check_irq("R8 irq released");

        // R9: read clears only the addressed slot
        pulse(1, 0);
        pulse(2, 1);
        do_read(4, "R9 slot 1 read", -1, 0);
        check_irq("R9 irq held by slot 2");
        do_read(5, "R9 slot 2 flag untouched", -1, 0);
        check_irq("R9 irq released");

        // R10: unmapped sweep
        pulse(0, 2);
        for (int a = 0; a < 256; a++) begin
            if (a < 3 || a > 5) do_read(a, "R10 unmapped reads zero", -1, 0);
        end
        check_irq("R10 irq unchanged by unmapped reads");
        do_read(3, "R10 flag survived unmapped reads", -1, 0);

        // R11: data held while idle
        pulse(2, 3);
        do_read(5, "R11 read", -1, 0);
        repeat (4) @(negedge clk);
        check("R11 data held", rd_data,
              {slot_active[2], 3'b000, 1'b1, slot_clk_int[2], 1'b0, slot_pres[2]});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule